// File: doc/BRIEF.md
# Per-Drive Perpendicular Recording Mode Selector

This block belongs to a four-drive floppy disk controller. It holds the perpendicular-recording configuration and decides, at the start of each write, how the selected drive is recorded. Software loads the configuration one command byte at a time. The byte carries two global mode bits, one automatic-perpendicular bit for each drive, and an overwrite-enable bit. The per-drive bits let perpendicular drives and conventional drives share the controller. No new command is needed when the controller moves from one drive type to the other.

When the write sequencer starts a sector write, it pulses `wr_start`. At that edge the block samples the drive number and the data rate and fixes the result for the whole write. The result is the recording mode, the Gap2 length, the byte at which write gate turns on, and the write pre-compensation code. A command that arrives during the write does not touch that write.

The command port is a valid/ready stream. `cmd_ready` is high in every cycle except the cycles in which a software reset is requested. A byte is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. The sender must hold the byte until that edge, and a byte offered while `cmd_ready` is low is not taken. The block never needs more than one cycle to take a byte. All other pins are plain control and status.

Top module: `pmode_sel`

## Requirements
- R1: `cmd_ready` is high except in cycles where `soft_rst` is high. A byte is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. Byte layout: bit 0 is the global long-gap bit and bit 1 is the global early-gate bit. Bit 2+n is the automatic bit for drive n (bits 2 to 5 for drives 0 to 3). Bit 7 is overwrite-enable, and bit 6 is ignored. Every accepted byte loads both global bits.
- R2: The four per-drive bits are loaded from an accepted byte only when its bit 7 is 1. Otherwise they keep their values.
- R3: When either global bit is 1, every drive is perpendicular, whatever its per-drive bit holds.
- R4: When both global bits are 0, drive n is perpendicular if its per-drive bit is 1 and conventional if it is 0.
- R5: `gap2_len` is 22 for a conventional write. For a perpendicular write it is 38 when `rate` is 2'b11 (1 Mbps) and 19 for every other rate. The rate codes are 2'b00 for 500 Kbps, 2'b01 for 300 Kbps and 2'b10 for 250 Kbps.
- R6: `wgate_pos` counts bytes from the first Gap2 byte as 0. For a conventional write it equals `gap2_len`, which is the first sync byte. For a perpendicular write it is 1, which is inside Gap2.
- R7: `precomp_out` is 0 while `perp_mode` is 1. Otherwise it follows `precomp_in` combinationally.
- R8: `perp_mode`, `gap2_len` and `wgate_pos` change only on an edge where `wr_start` is high. They are computed from the configuration held before that edge and from the `drv_sel` and `rate` values at that edge. A byte accepted on the same edge applies only from the next write.
- R9: A `soft_rst` edge clears both global bits and keeps the per-drive bits. It does not change the outputs latched for the current write.
- R10: `rst_n` low clears every configuration bit at once, with no clock edge needed. It also returns the outputs to conventional mode: `perp_mode` 0, `gap2_len` 22 and `wgate_pos` 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| soft_rst | input | 1 | Software reset request, synchronous |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte can be taken |
| cmd_data | input | 8 | Command byte |
| drv_sel | input | 2 | Selected drive number |
| rate | input | 2 | Programmed data rate code |
| precomp_in | input | 3 | Programmed write pre-compensation code |
| wr_start | input | 1 | Start-of-write strobe |
| perp_mode | output | 1 | Latched mode: 1 means perpendicular |
| gap2_len | output | 6 | Gap2 byte count for this write |
| wgate_pos | output | 6 | Byte at which write gate turns on |
| precomp_out | output | 3 | Pre-compensation code to apply |

## Verification
Some properties are checked on every cycle:
- A software reset clears the global bits and leaves the per-drive bits alone.
- A byte without overwrite-enable leaves the per-drive bits unchanged.
- The latched outputs move only on a write strobe.
- A set global bit forces the next write to perpendicular.
- The Gap2 length and the write-gate position stay consistent with the mode.

Other behaviour only the bench scenarios can show:
- The drive-by-rate decode for each stored pattern.
- The gating of pre-compensation.
- The ordering when a command, a software reset and a write strobe share one edge.
- That a hardware reset clears the per-drive bits while a software reset keeps them.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  localparam int NUM_DRV = 4;
  localparam int DSEL_W  = $clog2(NUM_DRV);
  localparam int CMD_W   = 8;
  localparam int GAP_W   = 6;
  localparam int PC_W    = 3;

  localparam int BIT_GAP = 0;
  localparam int BIT_WG  = 1;
  localparam int BIT_D0  = 2;
  localparam int BIT_OW  = 7;

  typedef enum logic [1:0] {
    RATE_500K = 2'b00,
    RATE_300K = 2'b01,
    RATE_250K = 2'b10,
    RATE_1M   = 2'b11
  } rate_e;

  localparam logic [GAP_W-1:0] GAP2_CONV    = 6'd22;
  localparam logic [GAP_W-1:0] GAP2_PERP_HI = 6'd38;
  localparam logic [GAP_W-1:0] GAP2_PERP_LO = 6'd19;
  localparam logic [GAP_W-1:0] WG_PERP_POS  = 6'd1;

  typedef struct packed {
    logic             perp;
    logic [GAP_W-1:0] gap2;
    logic [GAP_W-1:0] wgpos;
  } wr_plan_t;
endpackage

// File: rtl/pmode_cfg_reg.sv
module pmode_cfg_reg
  import pmode_pkg::*;
#(
  parameter int NDRV = NUM_DRV,
  parameter int CW   = CMD_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [CW-1:0]   cmd_data,
  output logic            glob_gap,
  output logic            glob_wg,
  output logic [NDRV-1:0] drv_auto
);
  logic take;
  logic unused_spare;

  assign cmd_ready    = !soft_rst;
  assign take         = cmd_valid && cmd_ready;
  assign unused_spare = cmd_data[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_gap <= 1'b0;
      glob_wg  <= 1'b0;
      drv_auto <= '0;
    end else if (soft_rst) begin
      glob_gap <= 1'b0;
      glob_wg  <= 1'b0;
    end else if (take) begin
      glob_gap <= cmd_data[BIT_GAP];
      glob_wg  <= cmd_data[BIT_WG];
      if (cmd_data[BIT_OW]) begin
        drv_auto <= cmd_data[BIT_D0 +: NDRV];
      end
    end
  end
endmodule

// File: rtl/pmode_resolve.sv
module pmode_resolve
  import pmode_pkg::*;
#(
  parameter int NDRV = NUM_DRV,
  parameter int SW   = DSEL_W
) (
  input  logic            glob_gap,
  input  logic            glob_wg,
  input  logic [NDRV-1:0] drv_auto,
  input  logic [SW-1:0]   drv_sel,
  input  logic [1:0]      rate,
  output wr_plan_t        plan
);
  logic            glob_any;
  logic [NDRV-1:0] perp_vec;
  logic            perp_sel;
  logic [GAP_W-1:0] perp_gap;

  assign glob_any = glob_gap || glob_wg;

  for (genvar d = 0; d < NDRV; d++) begin : g_drv
    assign perp_vec[d] = glob_any ? 1'b1 : drv_auto[d];
  end

  assign perp_sel = perp_vec[drv_sel];
  assign perp_gap = (rate_e'(rate) == RATE_1M) ? GAP2_PERP_HI : GAP2_PERP_LO;

  always_comb begin
    plan.perp  = perp_sel;
    plan.gap2  = perp_sel ? perp_gap : GAP2_CONV;
    plan.wgpos = perp_sel ? WG_PERP_POS : GAP2_CONV;
  end
endmodule

// File: rtl/pmode_latch.sv
module pmode_latch
  import pmode_pkg::*;
#(
  parameter int PW = PC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  wr_plan_t      plan,
  input  logic [PW-1:0] precomp_in,
  output logic          perp_mode,
  output logic [GAP_W-1:0] gap2_len,
  output logic [GAP_W-1:0] wgate_pos,
  output logic [PW-1:0] precomp_out
);
  wr_plan_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held.perp  <= 1'b0;
      held.gap2  <= GAP2_CONV;
      held.wgpos <= GAP2_CONV;
    end else if (wr_start) begin
      held <= plan;
    end
  end

  assign perp_mode   = held.perp;
  assign gap2_len    = held.gap2;
  assign wgate_pos   = held.wgpos;
  assign precomp_out = held.perp ? '0 : precomp_in;
endmodule

// File: rtl/pmode_sel.sv
module pmode_sel
  import pmode_pkg::*;
#(
  parameter int NDRV = NUM_DRV,
  parameter int SW   = DSEL_W,
  parameter int CW   = CMD_W,
  parameter int PW   = PC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CW-1:0]    cmd_data,
  input  logic [SW-1:0]    drv_sel,
  input  logic [1:0]       rate,
  input  logic [PW-1:0]    precomp_in,
  input  logic             wr_start,
  output logic             perp_mode,
  output logic [GAP_W-1:0] gap2_len,
  output logic [GAP_W-1:0] wgate_pos,
  output logic [PW-1:0]    precomp_out
);
  logic            glob_gap;
  logic            glob_wg;
  logic [NDRV-1:0] drv_auto;
  wr_plan_t        plan;

  pmode_cfg_reg #(.NDRV(NDRV), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .glob_gap(glob_gap), .glob_wg(glob_wg), .drv_auto(drv_auto)
  );

  pmode_resolve #(.NDRV(NDRV), .SW(SW)) u_res (
    .glob_gap(glob_gap), .glob_wg(glob_wg), .drv_auto(drv_auto),
    .drv_sel(drv_sel), .rate(rate), .plan(plan)
  );

  pmode_latch #(.PW(PW)) u_lat (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .plan(plan),
    .precomp_in(precomp_in), .perp_mode(perp_mode), .gap2_len(gap2_len),
    .wgate_pos(wgate_pos), .precomp_out(precomp_out)
  );
endmodule

// File: rtl/pmode_sel_chk.sv
module pmode_sel_chk
  import pmode_pkg::*;
#(
  parameter int NDRV = NUM_DRV,
  parameter int CW   = CMD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [CW-1:0]    cmd_data,
  input logic             wr_start,
  input logic             glob_gap,
  input logic             glob_wg,
  input logic [NDRV-1:0]  drv_auto,
  input logic             perp_mode,
  input logic [GAP_W-1:0] gap2_len,
  input logic [GAP_W-1:0] wgate_pos
);
  AST_SOFT_CLR_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> (!glob_gap && !glob_wg)); // R9
  AST_SOFT_KEEPS_DRV: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> $stable(drv_auto)); // R9
  AST_NO_OW_KEEPS_DRV: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_ready && !cmd_data[BIT_OW]) |=> $stable(drv_auto)); // R2
  AST_HOLD_BETWEEN_WRITES: assert property (@(posedge clk) disable iff (!rst_n) !wr_start |=> ($stable(perp_mode) && $stable(gap2_len) && $stable(wgate_pos))); // R8
  AST_GLOBAL_FORCES_PERP: assert property (@(posedge clk) disable iff (!rst_n) (wr_start && (glob_gap || glob_wg)) |=> perp_mode); // R3
  AST_GAP_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n) perp_mode == (gap2_len != GAP2_CONV)); // R5
  AST_GATE_INSIDE_GAP: assert property (@(posedge clk) disable iff (!rst_n) perp_mode |-> (wgate_pos < gap2_len)); // R6
  AST_GATE_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n) !perp_mode |-> (wgate_pos == gap2_len)); // R6
endmodule

bind pmode_sel pmode_sel_chk #(.NDRV(NDRV), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_data(cmd_data), .wr_start(wr_start),
  .glob_gap(glob_gap), .glob_wg(glob_wg), .drv_auto(drv_auto),
  .perp_mode(perp_mode), .gap2_len(gap2_len), .wgate_pos(wgate_pos)
);

// File: tb/pmode_sel_bench.sv
`timescale 1ns/1ps
module pmode_sel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [7:0] cmd_data = 8'h00;
  logic [1:0] drv_sel = 2'd0;
  logic [1:0] rate = 2'd0;
  logic [2:0] precomp_in = 3'd0;
  logic       wr_start = 1'b0;
  logic       perp_mode;
  logic [5:0] gap2_len;
  logic [5:0] wgate_pos;
  logic [2:0] precomp_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmode_sel u_pmode_sel (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .drv_sel(drv_sel), .rate(rate),
    .precomp_in(precomp_in), .wr_start(wr_start), .perp_mode(perp_mode),
    .gap2_len(gap2_len), .wgate_pos(wgate_pos), .precomp_out(precomp_out)
  );

  // {req[3:0], cmdv, cmd[7:0], drv[1:0], rate[1:0], pc[2:0], eperp, egap[5:0], ewg[5:0]}
  localparam int NV = 12;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {4'd4,  1'b1, 8'h84, 2'd0, 2'b00, 3'd5, 1'b1, 6'd19, 6'd1},  // R4 drive 0 auto
    {4'd4,  1'b0, 8'h00, 2'd1, 2'b00, 3'd5, 1'b0, 6'd22, 6'd22}, // R4 drive 1 conventional
    {4'd2,  1'b1, 8'h20, 2'd3, 2'b11, 3'd3, 1'b0, 6'd22, 6'd22}, // R2 no overwrite
    {4'd3,  1'b1, 8'h01, 2'd1, 2'b11, 3'd4, 1'b1, 6'd38, 6'd1},  // R3 long-gap bit
    {4'd5,  1'b0, 8'h00, 2'd2, 2'b10, 3'd6, 1'b1, 6'd19, 6'd1},  // R5 250K uses 19
    {4'd3,  1'b1, 8'h02, 2'd3, 2'b01, 3'd2, 1'b1, 6'd19, 6'd1},  // R3 early-gate bit
    {4'd1,  1'b1, 8'h00, 2'd0, 2'b11, 3'd7, 1'b1, 6'd38, 6'd1},  // R1 globals cleared, D0 stays
    {4'd4,  1'b1, 8'h00, 2'd2, 2'b11, 3'd7, 1'b0, 6'd22, 6'd22}, // R4
    {4'd2,  1'b1, 8'hA8, 2'd0, 2'b00, 3'd2, 1'b0, 6'd22, 6'd22}, // R2 overwrite D1,D3
    {4'd6,  1'b0, 8'h00, 2'd3, 2'b11, 3'd1, 1'b1, 6'd38, 6'd1},  // R6
    {4'd5,  1'b0, 8'h00, 2'd1, 2'b00, 3'd1, 1'b1, 6'd19, 6'd1},  // R5
    {4'd1,  1'b1, 8'hC0, 2'd3, 2'b11, 3'd1, 1'b0, 6'd22, 6'd22}  // R1 bit 6 ignored
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input bit ep, input int eg, input int ew, input int epc);
    chk(req, "perp_mode", int'(perp_mode), int'(ep));
    chk(req, "gap2_len", int'(gap2_len), eg);
    chk(req, "wgate_pos", int'(wgate_pos), ew);
    chk(req, "precomp_out", int'(precomp_out), epc);
  endtask

  task automatic send_cmd(input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] d, input logic [1:0] r, input logic [2:0] pc);
    @(negedge clk);
    wr_start = 1'b1;
    drv_sel = d;
    rate = r;
    precomp_in = pc;
    @(negedge clk);
    wr_start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    precomp_in = 3'd6;
    #20;
    // R10 reset state, taken while reset is still low
    chk_out("R10", 1'b0, 22, 22, 6);
    chk("R1", "cmd_ready", int'(cmd_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      string rq;
      v = VEC[i];
      rq = $sformatf("R%0d", v[32:29]);
      if (v[28]) send_cmd(v[27:20]);
      do_write(v[19:18], v[17:16], v[15:13]);
      chk_out(rq, v[12], int'(v[11:6]), int'(v[5:0]), v[12] ? 0 : int'(v[15:13]));
    end

    // R7 pre-compensation follows its input combinationally while conventional
    @(negedge clk);
    precomp_in = 3'd3;
    #1;
    chk("R7", "precomp_out conv", int'(precomp_out), 3);
    send_cmd(8'h01);
    do_write(2'd0, 2'b00, 3'd5);
    @(negedge clk);
    precomp_in = 3'd7;
    #1;
    chk("R7", "precomp_out perp", int'(precomp_out), 0);

    // R8 a command without a write strobe leaves the latched result
    send_cmd(8'h00);
    @(negedge clk);
    chk_out("R8", 1'b1, 19, 1, 0);
    // R8 command and strobe on one edge: the strobe sees the old configuration
    send_cmd(8'h02);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data = 8'h00;
    wr_start = 1'b1;
    drv_sel = 2'd2;
    rate = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    wr_start = 1'b0;
    chk_out("R8", 1'b1, 38, 1, 0);
    do_write(2'd2, 2'b11, 3'd4);
    chk_out("R8", 1'b0, 22, 22, 4);

    // R9 software reset: globals cleared, per-drive bits kept, outputs held
    send_cmd(8'h85);
    do_write(2'd1, 2'b00, 3'd2);
    chk_out("R9", 1'b1, 19, 1, 0);
    @(negedge clk);
    soft_rst = 1'b1;
    cmd_valid = 1'b1;
    cmd_data = 8'h81;
    #1;
    chk("R1", "cmd_ready during soft reset", int'(cmd_ready), 0);
    @(negedge clk);
    soft_rst = 1'b0;
    cmd_valid = 1'b0;
    #1;
    chk("R1", "cmd_ready after soft reset", int'(cmd_ready), 1);
    chk_out("R9", 1'b1, 19, 1, 0);
    do_write(2'd1, 2'b00, 3'd2);
    chk_out("R9", 1'b0, 22, 22, 2);
    do_write(2'd0, 2'b11, 3'd2);
    chk_out("R9", 1'b1, 38, 1, 0);

    // R10 hardware reset clears the per-drive bits
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_out("R10", 1'b0, 22, 22, 2);
    @(negedge clk);
    rst_n = 1'b1;
    do_write(2'd0, 2'b11, 3'd5);
    chk_out("R10", 1'b0, 22, 22, 5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule